// File: doc/BRIEF.md
# Multiplexed Host Bus Register Slave with Timing-Style Detection

This block gives a host processor access to a small register file over one shared address/data bus. Each access starts with an address phase: the host drives the register address onto the bus and pulses an address-latch line. A data phase follows, in which the host reads or writes the register at that address. Two families of host timing are accepted. In the first family, one line is a read strobe and the other is a write strobe. In the second family, one line is a data strobe and the other is a read/write direction level. The block chooses between them at every address phase by looking at the strobe levels, so it needs no mode pin.

Behind the bus sit five read/write control registers, at addresses 0 to 4. Their contents drive the `ctrl_o` port. Three read-only status bytes sit at addresses 5 to 7; they are taken live from the `stat_i` input. Every strobe passes through a two-stage synchroniser into the internal clock domain. All decisions are made on edges of the synchronised copies. The block does not model the tristate pad. It outputs the read data together with an output-enable.

Top module: `mbus_slave`

## Requirements
- R1: The register address is taken from `ad_i` when the synchronised `latch_i` falls. Bus values seen during the data phase do not change which register is accessed.
- R2: At each falling edge of the synchronised latch, the bus style is set to data-strobe style if `strb_b_i` is low and `strb_a_n_i` is high. Otherwise it is set to read/write-strobe style. In data-strobe style, toggling `strb_b_i` without a data strobe writes nothing. The style is held until the next address latch.
- R3: In read/write-strobe style, a write is a low pulse on `strb_b_i`. `ad_i` is stored into the addressed control register when the synchronised `strb_b_i` rises.
- R4: In data-strobe style, a write is a low pulse on `strb_a_n_i` while `strb_b_i` is low. `ad_i` is stored into the addressed control register when the synchronised `strb_a_n_i` rises.
- R5: A read is active while the synchronised `strb_a_n_i` is low. In data-strobe style, `strb_b_i` must also be high. During a read, `ad_oe_o` is 1 and `ad_o` shows the addressed register. At all other times `ad_oe_o` is 0. A data strobe with `strb_b_i` low never drives the bus.
- R6: Address 5+k reads `stat_i[8k+7:8k]`, for k = 0, 1 and 2. The value is sampled at the time of the read.
- R7: A write to address 5, 6 or 7 changes no control register. The status bytes still read back from `stat_i`.
- R8: A read of any address at 8 or above returns 0x00.
- R9: After reset, all control registers are 0x00, `ad_oe_o` is 0, `ad_o` is 0x00, and the bus style is read/write-strobe.
- R10: A write takes effect only when the strobe is released, and only once per release. While the strobe is held low, the target register keeps its old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ad_i | input | BW | Shared address/data bus, as seen by the block |
| latch_i | input | 1 | Address latch, active high; the address is taken on its fall |
| strb_a_n_i | input | 1 | Read strobe (read/write-strobe style) or data strobe (data-strobe style), active low |
| strb_b_i | input | 1 | Write strobe, active low (read/write-strobe style), or direction, high = read (data-strobe style) |
| stat_i | input | N_STAT*BW | Read-only status bytes, byte k at address N_CTRL+k |
| ctrl_o | output | N_CTRL*BW | Control register contents, register k at bits [BW*k+BW-1:BW*k] |
| ad_o | output | BW | Read data for the bus |
| ad_oe_o | output | 1 | High while the block drives read data |

## Verification
The bench builds the block with its default parameters: an 8-bit bus, five control registers and three status bytes. With an 8-bit address and only eight mapped registers, most of the address space is unmapped, so 0x08 and 0xFF can be read to exercise the zero return. Both bus styles are mixed within one run: each register is written in one style and read back in the other. Extra patterns check that the style is chosen anew at every latch. One pattern toggles only the direction line and must not write. Another holds a data strobe with the direction line low and must not drive the bus.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

    typedef enum logic {
        BUS_RWSTROBE = 1'b0,
        BUS_DSTROBE  = 1'b1
    } bus_mode_e;

endpackage

// File: rtl/mbus_sync.sv
module mbus_sync #(
    parameter int             W   = 1,
    parameter logic [W-1:0]   RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] s1_q, s1_d;
    logic [W-1:0] s2_q, s2_d;

    always_comb begin
        s1_d = d_i;
        s2_d = s1_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= RST;
            s2_q <= RST;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign q_o = s2_q;

endmodule

// File: rtl/mbus_regfile.sv
module mbus_regfile #(
    parameter int BW     = 8,
    parameter int N_CTRL = 5,
    parameter int N_STAT = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we_i,
    input  logic [BW-1:0]          addr_i,
    input  logic [BW-1:0]          wdata_i,
    input  logic [N_STAT*BW-1:0]   stat_i,
    output logic [N_CTRL*BW-1:0]   ctrl_o,
    output logic [BW-1:0]          rdata_o
);

    localparam int N_REG = N_CTRL + N_STAT;

    logic [BW-1:0] ctrl_q [N_CTRL];
    logic [BW-1:0] ctrl_d [N_CTRL];

    always_comb begin
        for (int i = 0; i < N_CTRL; i++) begin
            ctrl_d[i] = ctrl_q[i];
            if (we_i && addr_i == BW'(i)) begin
                ctrl_d[i] = wdata_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_CTRL; i++) ctrl_q[i] <= '0;
        end else begin
            for (int i = 0; i < N_CTRL; i++) ctrl_q[i] <= ctrl_d[i];
        end
    end

    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < N_CTRL; i++) begin
            if (addr_i == BW'(i)) rdata_o = ctrl_q[i];
        end
        for (int k = 0; k < N_STAT; k++) begin
            if (addr_i == BW'(N_CTRL + k)) rdata_o = stat_i[k*BW +: BW];
        end
    end

    generate
        for (genvar g = 0; g < N_CTRL; g++) begin : g_ctrl
            assign ctrl_o[g*BW +: BW] = ctrl_q[g];

            AST_CTRL_TAKES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
                (we_i && addr_i == BW'(g)) |=> ctrl_o[g*BW +: BW] == $past(wdata_i))
                else $error("control register %0d missed a write", g); // R3
        end
    endgenerate

    AST_RO_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i >= BW'(N_CTRL) && addr_i < BW'(N_REG)) |=> $stable(ctrl_o))
        else $error("write to status address changed a control register"); // R7

endmodule

// File: rtl/mbus_slave.sv
module mbus_slave
    import mbus_pkg::*;
#(
    parameter int BW     = 8,
    parameter int N_CTRL = 5,
    parameter int N_STAT = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [BW-1:0]          ad_i,
    input  logic                   latch_i,
    input  logic                   strb_a_n_i,
    input  logic                   strb_b_i,
    input  logic [N_STAT*BW-1:0]   stat_i,
    output logic [N_CTRL*BW-1:0]   ctrl_o,
    output logic [BW-1:0]          ad_o,
    output logic                   ad_oe_o
);

    localparam int         N_REG    = N_CTRL + N_STAT;
    localparam logic [2:0] SYNC_RST = 3'b011;   // {latch, strobe a, strobe b}

    typedef struct packed {
        logic [2:0]  prev;
        bus_mode_e   mode;
        logic [BW-1:0] addr;
        logic        we;
        logic [BW-1:0] wdata;
        logic        oe;
        logic [BW-1:0] dout;
    } st_t;

    localparam st_t ST_RST = '{prev: SYNC_RST, mode: BUS_RWSTROBE, addr: '0,
                               we: 1'b0, wdata: '0, oe: 1'b0, dout: '0};

    st_t q, d;

    logic [2:0]    raw_s;
    logic [2:0]    syn_s;
    logic          lat_s, a_s, b_s;
    logic          lat_fall, a_rise, b_rise;
    logic          wr_ev, rd_now;
    logic [BW-1:0] rdata;

    assign raw_s = {latch_i, strb_a_n_i, strb_b_i};

    mbus_sync #(.W(3), .RST(SYNC_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_s),
        .q_o   (syn_s)
    );

    mbus_regfile #(.BW(BW), .N_CTRL(N_CTRL), .N_STAT(N_STAT)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (q.we),
        .addr_i  (q.addr),
        .wdata_i (q.wdata),
        .stat_i  (stat_i),
        .ctrl_o  (ctrl_o),
        .rdata_o (rdata)
    );

    always_comb begin
        lat_s    = syn_s[2];
        a_s      = syn_s[1];
        b_s      = syn_s[0];
        lat_fall = q.prev[2] & ~lat_s;
        a_rise   = ~q.prev[1] & a_s;
        b_rise   = ~q.prev[0] & b_s;

        if (q.mode == BUS_DSTROBE) begin
            wr_ev  = a_rise & ~b_s;
            rd_now = ~a_s & b_s & ~lat_s;
        end else begin
            wr_ev  = b_rise;
            rd_now = ~a_s & ~lat_s;
        end

        d      = q;
        d.prev = syn_s;
        d.we   = 1'b0;

        if (lat_fall) begin
            d.addr = ad_i;
            d.mode = (~b_s & a_s) ? BUS_DSTROBE : BUS_RWSTROBE;
        end else if (wr_ev && !lat_s) begin
            d.we    = 1'b1;
            d.wdata = ad_i;
        end

        d.oe   = rd_now;
        d.dout = rd_now ? rdata : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= ST_RST;
        else        q <= d;
    end

    assign ad_o    = q.dout;
    assign ad_oe_o = q.oe;

    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !lat_fall |=> $stable(q.mode))
        else $error("bus style changed outside an address latch"); // R2

    AST_WRITE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        q.we |=> !q.we)
        else $error("one strobe release produced two writes"); // R10

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ad_oe_o && $past(q.addr) >= BW'(N_REG)) |-> ad_o == '0)
        else $error("unmapped read returned nonzero data"); // R8

    AST_NO_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.mode == BUS_DSTROBE && !b_s) |=> !ad_oe_o)
        else $error("bus driven while direction line selects write"); // R5

endmodule

// File: tb/mbus_slave_test.sv
`timescale 1ns/1ps
module mbus_slave_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  ad = 8'h00;
    logic        latch = 1'b0;
    logic        strb_a = 1'b1;
    logic        strb_b = 1'b1;
    logic [23:0] stat = 24'hC35AA5;
    logic [39:0] ctrl;
    logic [7:0]  ad_o;
    logic        ad_oe;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    mbus_slave uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ad_i       (ad),
        .latch_i    (latch),
        .strb_a_n_i (strb_a),
        .strb_b_i   (strb_b),
        .stat_i     (stat),
        .ctrl_o     (ctrl),
        .ad_o       (ad_o),
        .ad_oe_o    (ad_oe)
    );

    typedef struct packed {
        logic       ds;
        logic [7:0] addr;
        logic [7:0] data;
        logic [7:0] exp;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{1'b0, 8'h00, 8'h11, 8'h11},
        '{1'b1, 8'h01, 8'h22, 8'h22},
        '{1'b0, 8'h02, 8'hA7, 8'hA7},
        '{1'b1, 8'h03, 8'h3C, 8'h3C},
        '{1'b0, 8'h04, 8'hFF, 8'hFF},
        '{1'b1, 8'h05, 8'h99, 8'hA5},
        '{1'b0, 8'h06, 8'h77, 8'h5A},
        '{1'b1, 8'h07, 8'h01, 8'hC3}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic latch_addr(input logic [7:0] a, input logic ds);
        @(negedge clk);
        ad     = a;
        strb_a = 1'b1;
        strb_b = ds ? 1'b0 : 1'b1;
        latch  = 1'b1;
        wait_n(3);
        latch  = 1'b0;
        wait_n(4);
    endtask

    task automatic do_write(input logic ds, input logic [7:0] a, input logic [7:0] dt);
        latch_addr(a, ds);
        ad = dt;
        if (!ds) begin
            strb_b = 1'b0; wait_n(4);
            strb_b = 1'b1; wait_n(5);
        end else begin
            strb_a = 1'b0; wait_n(4);
            strb_a = 1'b1; wait_n(5);
            strb_b = 1'b1; wait_n(2);
        end
    endtask

    task automatic do_read(input logic ds, input logic [7:0] a,
                           output logic [7:0] v, output logic oe);
        latch_addr(a, ds);
        ad = 8'h00;
        if (ds) begin
            strb_b = 1'b1; wait_n(3);
        end
        strb_a = 1'b0; wait_n(5);
        v  = ad_o;
        oe = ad_oe;
        strb_a = 1'b1; wait_n(5);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic       oe;

        wait_n(3);
        rst_n = 1'b1;
        wait_n(2);
        chk("R9 ctrl reset", ctrl, 40'h0);
        chk("R9 oe reset", ad_oe, 1'b0);
        chk("R9 data reset", ad_o, 8'h00);

        for (int i = 0; i < 8; i++) begin
            do_write(VEC[i].ds, VEC[i].addr, VEC[i].data);
            do_read(~VEC[i].ds, VEC[i].addr, v, oe);
            if (VEC[i].addr >= 8'h05)      chk("R7 status readback", v, VEC[i].exp);
            else if (VEC[i].ds)            chk("R4 readback", v, VEC[i].exp);
            else                           chk("R3 readback", v, VEC[i].exp);
            chk("R5 oe during read", oe, 1'b1);
        end
        chk("R3 ctrl image", ctrl, 40'hFF_3C_A7_22_11);
        chk("R5 oe idle", ad_oe, 1'b0);

        // R7: status write leaves control registers alone
        do_write(1'b0, 8'h05, 8'hEE);
        chk("R7 ctrl untouched", ctrl, 40'hFF_3C_A7_22_11);
        do_read(1'b0, 8'h05, v, oe);
        chk("R7 status still input", v, 8'hA5);

        // R10: no update while the write strobe is held
        latch_addr(8'h02, 1'b0);
        ad = 8'h5E;
        strb_b = 1'b0; wait_n(6);
        chk("R10 held strobe", ctrl[23:16], 8'hA7);
        strb_b = 1'b1; wait_n(5);
        chk("R10 after release", ctrl[23:16], 8'h5E);

        // R2: data-strobe style ignores direction toggles without a data strobe
        latch_addr(8'h01, 1'b1);
        ad = 8'h66;
        strb_b = 1'b1; wait_n(5);
        strb_b = 1'b0; wait_n(5);
        strb_b = 1'b1; wait_n(5);
        chk("R2 no write without data strobe", ctrl[15:8], 8'h22);
        do_write(1'b0, 8'h01, 8'h66);
        chk("R2 style re-chosen at latch", ctrl[15:8], 8'h66);

        // R1: data phase value that looks like an address does not redirect
        do_write(1'b0, 8'h04, 8'h00);
        chk("R1 target written", ctrl[39:32], 8'h00);
        chk("R1 other reg kept", ctrl[7:0], 8'h11);

        // R5 / R4: data strobe with direction low is a write, never drives the bus
        latch_addr(8'h00, 1'b1);
        ad = 8'h00;
        strb_a = 1'b0; wait_n(5);
        chk("R5 no drive on write", ad_oe, 1'b0);
        strb_a = 1'b1; wait_n(5);
        strb_b = 1'b1; wait_n(2);
        chk("R4 data strobe write", ctrl[7:0], 8'h00);

        // R8: unmapped reads
        do_read(1'b0, 8'h08, v, oe);
        chk("R8 unmapped 0x08", v, 8'h00);
        chk("R8 oe on unmapped", oe, 1'b1);
        do_read(1'b1, 8'hFF, v, oe);
        chk("R8 unmapped 0xFF", v, 8'h00);

        // R6: status follows the input
        stat = 24'h123456;
        do_read(1'b0, 8'h05, v, oe);
        chk("R6 status byte 0", v, 8'h56);
        do_read(1'b1, 8'h07, v, oe);
        chk("R6 status byte 2", v, 8'h12);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule